// File: doc/BRIEF.md
# UART Transmitter with Fractional Stop Length

This block turns parallel characters into an asynchronous serial stream. It runs from a 16x bit-rate clock enable: in the normal mode every bit lasts sixteen enable ticks. A character is five to eight data bits, sent least significant bit first. A parity bit may follow the data, and it can be even, odd, forced low or forced high. The frame ends with a high stop period whose length is set in sixteenths of a bit time. A 4-bit stop code selects this length, and the length the code gives depends on the character size. A separate mode treats each enable tick as one whole bit time. In that mode the stop period is one or two bits.

A single holding register takes bytes through a valid/ready handshake, so the next character can wait while the current one is shifting out. Clear-to-send flow control can be turned on. The active-low CTS input is then checked only when a character is about to begin. While CTS is deasserted the line stays idle. A character that has already started always runs to its end. Character size, parity, stop code and mode are captured when the start bit begins. Any change to them during a frame affects only the next character.

Top module: `uart_tx_fracstop`

## Requirements
- R1: After reset, txd is high, tx_ready is 1 and tx_empty is 1.
- R2: A frame has three parts in this order. First a low start bit. Then the data bits, least significant first. Then the stop period, with txd high. In 16x mode (one_x_mode=0) each start, data and parity bit lasts 16 ticks of tick_en.
- R3: char_len selects the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above the selected size are not sent.
- R4: par_mode selects the parity bit that follows the data. 000 is even (total of ones in data plus parity is even). 001 is odd. 010 forces the bit to 0 and 011 forces it to 1. 1xx sends no parity bit. Parity covers only the data bits that are sent.
- R5: In 16x mode, stop codes 0000–0111 give 9+code ticks of stop when the character has 6, 7 or 8 bits.
- R6: In 16x mode, stop codes 0000–0111 give 17+code ticks of stop when the character has 5 bits.
- R7: In 16x mode, stop codes 1000–1111 give 25+(code-8) ticks of stop for every character size.
- R8: With one_x_mode=1, each bit lasts one tick. The stop period is 1 tick when stop_code[3]=0 and 2 ticks when stop_code[3]=1.
- R9: With cts_en=1 and cts_n high, no character starts, txd stays high and the byte stays held. With cts_en=0, the level of cts_n has no effect.
- R10: A change on cts_n after a character has started does not alter that character.
- R11: tx_ready is high exactly when the holding register is free. A byte is taken on a cycle where in_valid and tx_ready are both high. A held byte starts right at the end of the previous stop period, with no idle gap.
- R12: tx_empty rises on the cycle after the last stop tick, and only when no byte is held. It is low while a frame is in flight or a byte is held.
- R13: char_len, par_mode, stop_code and one_x_mode are captured at the start bit. Changing them during a frame has no effect on that frame.
- R14: The transmitter advances only on cycles where tick_en is high. A held byte does not start while tick_en stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Bit-rate clock enable (16x, or 1x in one_x_mode) |
| in_data | input | 8 | Character to send |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | Holding register can accept a byte |
| char_len | input | 2 | Data bit count select (5 to 8) |
| par_mode | input | 3 | Parity mode select |
| stop_code | input | 4 | Stop length code |
| cts_en | input | 1 | Enables clear-to-send gating |
| cts_n | input | 1 | Clear-to-send, active low |
| one_x_mode | input | 1 | Each tick is one whole bit time |
| txd | output | 1 | Serial output, idle high |
| tx_ready | output | 1 | Transmitter can take a new byte |
| tx_empty | output | 1 | Nothing held, nothing shifting, stop finished |

## Verification
Frames are decoded at the serial pin for each character size combined with each of the five parity modes. These sweeps use data bytes whose upper bits are set, so a size error shows up as a wrong bit and a parity taken over unsent bits shows up as a wrong parity bit. All sixteen stop codes are swept for 5-bit and for 6-bit characters. Each sweep sends back-to-back frames, and the measured gap separates the two length tables from each other and from an off-by-one tick count. In 1x mode both stop settings are run. Further patterns cover a CTS hold, a CTS release, a CTS drop in mid-frame and CTS disabled. Another pattern changes the programming in mid-frame, and one holds tick_en low. Each of these shows that gating and capture act only at a character boundary.

// File: rtl/uart_tx_fs_pkg.sv
package uart_tx_fs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  // ticks per bit time in the oversampled mode
  localparam int OVS = 16;

  // parity select codes
  localparam logic [2:0] PAR_EVEN = 3'b000;
  localparam logic [2:0] PAR_ODD  = 3'b001;
  localparam logic [2:0] PAR_ZERO = 3'b010;
  localparam logic [2:0] PAR_ONE  = 3'b011;

endpackage

// File: rtl/uart_tx_fs_hold.sv
module uart_tx_fs_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              pop,
  output logic              full,
  output logic [DATA_W-1:0] data
);

  logic push;
  assign push     = in_valid && !full;
  assign in_ready = !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (push) begin
        full <= 1'b1;
        data <= in_data;
      end else if (pop) begin
        full <= 1'b0;
      end
    end
  end

  // R11: a held byte is never overwritten before it leaves
  assert_hold_stable_R11: assert property (@(posedge clk) disable iff (rst)
    (full && !pop) |=> (full && $stable(data)));

  // R11: a pop only happens when something is held
  assert_no_underflow_R11: assert property (@(posedge clk) disable iff (rst)
    pop |-> full);

endmodule

// File: rtl/uart_tx_fs_stoplen.sv
module uart_tx_fs_stoplen #(
  parameter int CNT_W = 6
) (
  input  logic [3:0]       code,
  input  logic             five_bit,
  input  logic             one_x,
  output logic [CNT_W-1:0] ticks
);

  localparam int BASE_SHORT = 9;
  localparam int BASE_FIVE  = 17;
  localparam int BASE_LONG  = 25;

  logic [CNT_W-1:0] base;

  always_comb begin
    if (code[3])       base = CNT_W'(BASE_LONG);
    else if (five_bit) base = CNT_W'(BASE_FIVE);
    else               base = CNT_W'(BASE_SHORT);

    if (one_x) ticks = code[3] ? CNT_W'(2) : CNT_W'(1);
    else       ticks = base + CNT_W'(code[2:0]);
  end

  // R5 R6 R7 R8: the decoded length is never zero and never beyond two bits
  always_comb begin
    assert_stop_range_R7: assert (ticks >= 1 && ticks <= CNT_W'(32));
  end

endmodule

// File: rtl/uart_tx_fs_cts.sv
module uart_tx_fs_cts #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cts_en,
  input  logic cts_n,
  output logic cts_ok
);

  logic [SYNC_STAGES-1:0] sync_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= cts_n;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], cts_n};
      end
    end
  endgenerate

  assign cts_ok = !cts_en || !sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/uart_tx_fs_shift.sv
module uart_tx_fs_shift
  import uart_tx_fs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              start_ok,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [1:0]        ld_len,
  input  logic [2:0]        ld_par,
  input  logic [CNT_W-1:0]  ld_stop,
  input  logic              ld_one_x,
  output logic              take,
  output logic              busy,
  output logic              txd
);

  localparam int IDX_W = $clog2(DATA_W);
  localparam int MIN_BITS = DATA_W - 3;

  tx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  last_idx_q;
  logic [DATA_W-1:0] shreg;
  logic              par_en_q;
  logic              par_q;
  logic [CNT_W-1:0]  stop_q;
  logic              one_x_q;

  logic [IDX_W-1:0]  ld_last_idx;
  logic [DATA_W-1:0] masked;
  logic              ld_par_bit;
  logic              bit_end;
  logic              stop_end;
  logic              launch;

  assign ld_last_idx = IDX_W'(MIN_BITS - 1) + IDX_W'(ld_len);

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      masked[i] = ld_data[i] && (IDX_W'(i) <= ld_last_idx);
    end
    case (ld_par)
      PAR_EVEN: ld_par_bit = ^masked;
      PAR_ODD:  ld_par_bit = ~^masked;
      PAR_ZERO: ld_par_bit = 1'b0;
      PAR_ONE:  ld_par_bit = 1'b1;
      default:  ld_par_bit = 1'b0;
    endcase
  end

  assign bit_end  = tick_en && (cnt == (one_x_q ? CNT_W'(0) : CNT_W'(OVS - 1)));
  assign stop_end = tick_en && (state == ST_STOP) && (cnt == stop_q - CNT_W'(1));
  assign launch   = start_ok && tick_en && ((state == ST_IDLE) || stop_end);
  assign take     = launch;
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      idx        <= '0;
      last_idx_q <= '0;
      shreg      <= '0;
      par_en_q   <= 1'b0;
      par_q      <= 1'b0;
      stop_q     <= CNT_W'(1);
      one_x_q    <= 1'b0;
      txd        <= 1'b1;
    end else if (launch) begin
      state      <= ST_START;
      cnt        <= '0;
      idx        <= '0;
      last_idx_q <= ld_last_idx;
      shreg      <= ld_data;
      par_en_q   <= !ld_par[2];
      par_q      <= ld_par_bit;
      stop_q     <= ld_stop;
      one_x_q    <= ld_one_x;
      txd        <= 1'b0;
    end else if (tick_en) begin
      case (state)
        ST_START: begin
          if (bit_end) begin
            state <= ST_DATA;
            cnt   <= '0;
            txd   <= shreg[0];
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_DATA: begin
          if (bit_end) begin
            cnt <= '0;
            if (idx == last_idx_q) begin
              if (par_en_q) begin
                state <= ST_PAR;
                txd   <= par_q;
              end else begin
                state <= ST_STOP;
                txd   <= 1'b1;
              end
            end else begin
              idx   <= idx + IDX_W'(1);
              shreg <= shreg >> 1;
              txd   <= shreg[1];
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_PAR: begin
          if (bit_end) begin
            state <= ST_STOP;
            cnt   <= '0;
            txd   <= 1'b1;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_STOP: begin
          if (stop_end) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: begin
          cnt <= '0;
        end
      endcase
    end
  end

  // R2: start bit drives the line low
  assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START) |-> !txd);

  // R2: stop period and idle keep the line high
  assert_stop_high_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STOP || state == ST_IDLE) |-> txd);

  // R14: nothing moves without a tick
  assert_tick_freeze_R14: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> ($stable(txd) && $stable(state) && $stable(cnt)));

  // R9: an idle transmitter stays idle while start is gated off
  assert_cts_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !start_ok) |=> (state == ST_IDLE));

  // R13: captured stop length does not change inside a frame
  assert_cfg_latched_R13: assert property (@(posedge clk) disable iff (rst)
    (busy && !launch) |=> $stable(stop_q));

endmodule

// File: rtl/uart_tx_fracstop.sv
module uart_tx_fracstop #(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        char_len,
  input  logic [2:0]        par_mode,
  input  logic [3:0]        stop_code,
  input  logic              cts_en,
  input  logic              cts_n,
  input  logic              one_x_mode,
  output logic              txd,
  output logic              tx_ready,
  output logic              tx_empty
);

  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              take;
  logic              busy;
  logic              cts_ok;
  logic [CNT_W-1:0]  stop_ticks;

  uart_tx_fs_hold #(.DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .pop      (take),
    .full     (hold_full),
    .data     (hold_data)
  );

  uart_tx_fs_cts #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
    .clk    (clk),
    .rst    (rst),
    .cts_en (cts_en),
    .cts_n  (cts_n),
    .cts_ok (cts_ok)
  );

  uart_tx_fs_stoplen #(.CNT_W(CNT_W)) u_stop (
    .code     (stop_code),
    .five_bit (char_len == 2'b00),
    .one_x    (one_x_mode),
    .ticks    (stop_ticks)
  );

  uart_tx_fs_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .start_ok (hold_full && cts_ok),
    .ld_data  (hold_data),
    .ld_len   (char_len),
    .ld_par   (par_mode),
    .ld_stop  (stop_ticks),
    .ld_one_x (one_x_mode),
    .take     (take),
    .busy     (busy),
    .txd      (txd)
  );

  assign tx_ready = !hold_full;
  assign tx_empty = !hold_full && !busy;

  // R12: empty implies ready
  assert_empty_ready_R12: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> tx_ready);

  // R12: an empty transmitter keeps the line idle
  assert_empty_idle_R12: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> txd);

endmodule

// File: tb/uart_tx_fracstop_tb.sv
module uart_tx_fracstop_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b1;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] char_len = 2'b11;
  logic [2:0] par_mode = 3'b100;
  logic [3:0] stop_code = 4'd7;
  logic       cts_en = 1'b0;
  logic       cts_n = 1'b1;
  logic       one_x_mode = 1'b0;
  logic       txd;
  logic       tx_ready;
  logic       tx_empty;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  uart_tx_fracstop u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .char_len(char_len),
    .par_mode(par_mode), .stop_code(stop_code), .cts_en(cts_en),
    .cts_n(cts_n), .one_x_mode(one_x_mode), .txd(txd),
    .tx_ready(tx_ready), .tx_empty(tx_empty)
  );

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 190000", cycles);
      report();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int exp_stop(input int code, input int nb, input bit x1);
    if (x1) return (code >= 8) ? 2 : 1;
    if (code >= 8) return 25 + code - 8;
    if (nb == 5) return 17 + code;
    return 9 + code;
  endfunction

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_data = d;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Decode one frame at the pin. last=1: no byte follows, check the empty flag.
  task automatic run_frame(input logic [7:0] d, input int nb, input int pm,
                           input int bt, input int st, input bit last, input string req);
    int waitc = 0;
    int ones = 0;
    int nbit;
    int cnt;
    bit exp_b;
    bit bad;
    while (txd !== 1'b0 && waitc < 3000) begin
      @(negedge clk);
      waitc++;
    end
    check(txd === 1'b0, {req, " start seen"}, txd, 0);
    for (int i = 0; i < nb; i++) ones += d[i];
    nbit = 1 + nb + ((pm < 4) ? 1 : 0);
    for (int b = 0; b < nbit; b++) begin
      if (b == 0) exp_b = 1'b0;
      else if (b <= nb) exp_b = d[b-1];
      else if (pm == 0) exp_b = ones[0];
      else if (pm == 1) exp_b = ~ones[0];
      else exp_b = (pm == 3);
      bad = 1'b0;
      for (int j = 0; j < bt; j++) begin
        if (!(b == 0 && j == 0)) @(negedge clk);
        if (txd !== exp_b) bad = 1'b1;
      end
      check(!bad, {req, (b == 0) ? " R2 start" : (b <= nb) ? " R3 data" : " R4 parity"},
            bad ? int'(!exp_b) : int'(exp_b), int'(exp_b));
    end
    cnt = 0;
    if (!last) begin
      @(negedge clk);
      while (txd === 1'b1 && cnt < 80) begin
        cnt++;
        @(negedge clk);
      end
      check(cnt == st, {req, " stop gap"}, cnt, st);
    end else begin
      bad = 1'b0;
      for (int j = 0; j < st; j++) begin
        @(negedge clk);
        if (txd !== 1'b1) bad = 1'b1;
      end
      check(!bad && tx_empty === 1'b0, {req, " R12 last stop"}, tx_empty, 0);
      @(negedge clk);
      check(tx_empty === 1'b1 && txd === 1'b1, {req, " R12 empty after stop"}, tx_empty, 1);
    end
  endtask

  task automatic pair(input logic [7:0] a, input logic [7:0] b, input int nb,
                      input int pm, input int code, input bit x1, input string req);
    int bt;
    int st;
    bt = x1 ? 1 : 16;
    st = exp_stop(code, nb, x1);
    char_len = 2'(nb - 5);
    par_mode = 3'(pm);
    stop_code = 4'(code);
    one_x_mode = x1;
    push(a);
    fork
      push(b);
      run_frame(a, nb, pm, bt, st, 1'b0, req);
    join
    run_frame(b, nb, pm, bt, st, 1'b1, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(txd === 1'b1, "R1 txd", txd, 1);
    check(tx_ready === 1'b1 && in_ready === 1'b1, "R1 ready", tx_ready, 1);
    check(tx_empty === 1'b1, "R1 empty", tx_empty, 1);

    // R2 R3 R4: every size with every parity mode, upper bits set
    for (int nb = 5; nb <= 8; nb++) begin
      for (int pm = 0; pm < 5; pm++) begin
        pair(8'hE5 ^ 8'(pm * 37), 8'hB6 ^ 8'(nb * 19), nb, pm,
             (nb * 5 + pm) % 16, 1'b0, "R2_R3_R4 sweep");
      end
    end

    // R5 R6 R7: all stop codes for 5-bit and 6-bit characters
    for (int code = 0; code < 16; code++) begin
      pair(8'h1B, 8'h0E, 5, 4, code, 1'b0, (code < 8) ? "R6 five-bit stop" : "R7 long stop");
      pair(8'h2D, 8'h33, 6, 1, code, 1'b0, (code < 8) ? "R5 short stop" : "R7 long stop");
    end
    pair(8'hA5, 8'h5A, 8, 0, 0, 1'b0, "R5 eight-bit min stop");

    // R8: one tick per bit
    pair(8'hC3, 8'h3C, 8, 0, 3, 1'b1, "R8 1x one stop");
    pair(8'h96, 8'h69, 7, 1, 12, 1'b1, "R8 1x two stop");
    pair(8'h11, 8'h1E, 5, 4, 15, 1'b1, "R8 1x five bit");

    // R9 R10: CTS gating
    one_x_mode = 1'b0;
    char_len = 2'b11;
    par_mode = 3'b100;
    stop_code = 4'd7;
    cts_en = 1'b1;
    cts_n = 1'b1;
    push(8'h4D);
    begin
      bit bad = 1'b0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (txd !== 1'b1 || tx_ready !== 1'b0 || tx_empty !== 1'b0) bad = 1'b1;
      end
      check(!bad, "R9 held while cts deasserted", txd, 1);
    end
    cts_n = 1'b0;
    fork
      run_frame(8'h4D, 8, 4, 16, 16, 1'b1, "R10 cts drop mid-frame");
      begin
        repeat (40) @(negedge clk);
        cts_n = 1'b1;
      end
    join
    push(8'hB2);
    begin
      bit bad = 1'b0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (txd !== 1'b1) bad = 1'b1;
      end
      check(!bad, "R9 second byte waits", txd, 1);
    end
    cts_en = 1'b0;
    run_frame(8'hB2, 8, 4, 16, 16, 1'b1, "R9 cts disabled ignores pin");

    // R11: ready drops while held, returns when the frame starts
    push(8'h77);
    check(tx_ready === 1'b0 || txd === 1'b0, "R11 ready after push", tx_ready, 0);
    run_frame(8'h77, 8, 4, 16, 16, 1'b1, "R11 single");

    // R13: programming changed in mid-frame
    char_len = 2'b11;
    par_mode = 3'b000;
    stop_code = 4'd15;
    push(8'hF0);
    fork
      push(8'h0F);
      run_frame(8'hF0, 8, 0, 16, 32, 1'b0, "R13 old config kept");
      begin
        repeat (50) @(negedge clk);
        char_len = 2'b00;
        par_mode = 3'b011;
        stop_code = 4'd2;
      end
    join
    run_frame(8'h0F, 5, 3, 16, 19, 1'b1, "R13 new config next");

    // R14: no start without ticks
    char_len = 2'b11;
    par_mode = 3'b100;
    stop_code = 4'd7;
    tick_en = 1'b0;
    push(8'h81);
    begin
      bit bad = 1'b0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (txd !== 1'b1 || tx_ready !== 1'b0) bad = 1'b1;
      end
      check(!bad, "R14 frozen without tick", txd, 1);
    end
    tick_en = 1'b1;
    run_frame(8'h81, 8, 4, 16, 16, 1'b1, "R14 resumes");

    report();
  end

endmodule